// File: doc/BRIEF.md
# Compact 16-bit instruction decoder

This block turns one 16-bit compact-encoding instruction word into a decoded operation bundle for the execute stage of a core. The bundle names the operation class, the ALU operation, the full 5-bit source and destination register indices, the immediate after extension and scaling, the memory access size and signedness, and flags for load, store and register write. The decoder covers the 32-bit subset of the encoding: register-based and stack-relative loads and stores, ALU immediates, register-register ALU operations, immediate shifts, set-less-than and compare, and multiply/divide. Every other encoding is reported as illegal.

Instruction words enter on a valid/ready stream and decoded bundles leave on a second valid/ready stream. The decode logic is combinational and is followed by a single register stage. A word is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or when the consumer takes its bundle in the same cycle. While `out_valid` is high and `out_ready` is low, the bundle is held unchanged and no new word is accepted. A bundle appears on the output one clock after its word is accepted.

Top module: `m16_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. An accepted word produces its bundle with `out_valid` high on the next clock. While `out_valid && !out_ready`, the bundle stays constant. Clocking with `in_valid` low and `in_ready` high clears `out_valid`.
- R2: A 3-bit register field of value 0 maps to register 16, value 1 maps to 17, and values 2 to 7 map to the register of the same number. Fields are rx = bits [10:8], ry = [7:5] and rz = [4:2].
- R3: `out_class` is 0 for ALU, 1 for load, 2 for store, 3 for multiply/divide and 4 for illegal. `out_alu_op` is 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 SLT, 7 SLTU, 8 SLL, 9 SRL, 10 SRA, 11 MULT, 12 MULTU, 13 DIV and 14 DIVU. `out_size` is 0 for byte, 1 for halfword and 2 for word.
- R4: Register-based loads decode from bits [15:11] as follows: 10000 signed byte, 10100 unsigned byte, 10001 signed half, 10101 unsigned half, 10011 word. Stores decode as 11000 byte, 11001 half, 11011 word. Each has base src_a = map(rx) and alu_op ADD. The immediate is bits [4:0] zero-extended and multiplied by 1, 2 or 4 according to size. A load writes dst = map(ry). A store reads src_b = map(ry) and writes nothing.
- R5: Major 10010 is a stack-relative word load into dst = map(rx). Major 11010 is a stack-relative word store of src_b = map(rx). Both use base src_a = 29 and the immediate bits [7:0] zero-extended times 4.
- R6: Major 01000 with bit 4 = 0 computes dst = map(ry) from src_a = map(rx) plus bits [3:0] sign-extended. Major 01001 adds bits [7:0] sign-extended to map(rx) and writes the result back to map(rx). Major 01101 is OR of src_a = 0 with bits [7:0] zero-extended, written to map(rx).
- R7: Major 01010 (SLT), major 01011 (SLTU) and major 01110 (XOR) compare map(rx) with bits [7:0] zero-extended and write register 24.
- R8: Major 01110 is not a shift. Major 00110 is the immediate shift, with bits [1:0] selecting the operation: 00 SLL, 10 SRL, 11 SRA. It shifts src_a = map(ry) into dst = map(rx). The shift amount is taken from bits [4:2], where 0 means 8.
- R9: Major 11100 with bits [1:0] = 01 (ADD) or 11 (SUB) computes dst = map(rz) from src_a = map(rx) and src_b = map(ry).
- R10: Major 11101 selects an operation by bits [4:0]. Codes 00010 SLT, 00011 SLTU and 01010 CMP (XOR) take map(rx) and map(ry) and write register 24. Codes 01100 AND, 01101 OR and 01110 XOR take map(rx) and map(ry) and write map(rx). Code 01011 (SUB) and code 01111 (NOR) take src_a = 0 and src_b = map(ry) and write map(rx).
- R11: Under major 11101, codes 11000 MULT, 11001 MULTU, 11010 DIV and 11011 DIVU have class 3, take map(rx) and map(ry), and have `out_wr_en` = 0.
- R12: Any other word sets `out_illegal` = 1 and class 4. For such a word every other bundle field, including all write and memory flags, is 0.
- R13: Operations without an immediate give `out_use_imm` = 0 and `out_imm` = 0. Register indices that an operation does not use are 0. Non-memory operations give size 0 and unsigned 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_instr | input | 16 | Instruction word |
| out_ready | input | 1 | Consumer takes the bundle this cycle |
| out_valid | output | 1 | Bundle is present |
| out_class | output | 3 | Operation class code |
| out_alu_op | output | 4 | ALU operation code |
| out_src_a | output | 5 | First source register index |
| out_src_b | output | 5 | Second source register index |
| out_dst | output | 5 | Destination register index |
| out_imm | output | IMM_W | Extended and scaled immediate |
| out_use_imm | output | 1 | Immediate replaces the second operand |
| out_size | output | 2 | Memory access size code |
| out_unsigned | output | 1 | Load is zero-extending |
| out_is_load | output | 1 | Operation is a load |
| out_is_store | output | 1 | Operation is a store |
| out_wr_en | output | 1 | Operation writes `out_dst` |
| out_illegal | output | 1 | Word is not a recognised encoding |

## Verification
The assertions take for granted that `out_ready` and `in_valid` carry known values on every edge after reset. They also assume the consumer may withhold `out_ready` for any length of time, since a held bundle is expected to stay bit-identical during such a stall. The stimulus drives inputs only at the falling clock edge with defined values. It sweeps all 65,536 instruction words with the consumer always ready, then adds a stall and an idle cycle, so every assertion sees both decoded and illegal bundles under flowing and stalled output.

// File: rtl/m16_dec_pkg.sv
package m16_dec_pkg;
  typedef enum logic [2:0] {
    CLS_ALU = 3'd0, CLS_LOAD = 3'd1, CLS_STORE = 3'd2, CLS_MULDIV = 3'd3, CLS_NONE = 3'd4
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3, ALU_XOR = 4'd4,
    ALU_NOR = 4'd5, ALU_SLT = 4'd6, ALU_SLTU = 4'd7, ALU_SLL = 4'd8, ALU_SRL = 4'd9,
    ALU_SRA = 4'd10, ALU_MULT = 4'd11, ALU_MULTU = 4'd12, ALU_DIV = 4'd13, ALU_DIVU = 4'd14
  } alu_op_e;

  localparam int INSTR_W = 16;
  localparam int FIELD_W = 3;
  localparam int REG_W   = 5;
  localparam int SIZE_W  = 2;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_CMP  = 5'd24;
  localparam logic [REG_W-1:0] REG_SP   = 5'd29;
endpackage

// File: rtl/m16_regmap.sv
module m16_regmap
  import m16_dec_pkg::*;
(
  input  logic [FIELD_W-1:0] fld,
  output logic [REG_W-1:0]   reg_idx
);
  // codes 0 and 1 reach the upper pair 16/17, the rest index directly
  always_comb begin
    if (fld < FIELD_W'(2)) reg_idx = {4'b1000, fld[0]};
    else                   reg_idx = REG_W'(fld);
  end
endmodule

// File: rtl/m16_decode_core.sv
module m16_decode_core
  import m16_dec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [REG_W-1:0]   rx_m,
  input  logic [REG_W-1:0]   ry_m,
  input  logic [REG_W-1:0]   rz_m,
  output logic [2:0]         cls,
  output logic [3:0]         alu_op,
  output logic [REG_W-1:0]   src_a,
  output logic [REG_W-1:0]   src_b,
  output logic [REG_W-1:0]   dst,
  output logic [IMM_W-1:0]   imm,
  output logic               use_imm,
  output logic [SIZE_W-1:0]  size,
  output logic               uns,
  output logic               is_load,
  output logic               is_store,
  output logic               wr_en,
  output logic               illegal
);
  logic [4:0] major, fn5;
  logic [1:0] fn2;
  logic [2:0] shamt;
  logic [SIZE_W-1:0] msz;

  assign major = instr[15:11];
  assign fn5   = instr[4:0];
  assign fn2   = instr[1:0];
  assign shamt = instr[4:2];
  // access size from the low opcode bits shared by the load and store groups
  assign msz   = major[1] ? SZ_WORD : (major[0] ? SZ_HALF : SZ_BYTE);

  always_comb begin
    cls = CLS_NONE; alu_op = ALU_ADD; src_a = REG_ZERO; src_b = REG_ZERO; dst = REG_ZERO;
    imm = '0; use_imm = 1'b0; size = SZ_BYTE; uns = 1'b0;
    is_load = 1'b0; is_store = 1'b0; wr_en = 1'b0; illegal = 1'b1;
    case (major)
      5'b10000, 5'b10100, 5'b10001, 5'b10101, 5'b10011: begin
        illegal = 1'b0; cls = CLS_LOAD; is_load = 1'b1; wr_en = 1'b1; use_imm = 1'b1;
        src_a = rx_m; dst = ry_m; size = msz; uns = major[2];
        imm = IMM_W'(instr[4:0]) << msz;
      end
      5'b11000, 5'b11001, 5'b11011: begin
        illegal = 1'b0; cls = CLS_STORE; is_store = 1'b1; use_imm = 1'b1;
        src_a = rx_m; src_b = ry_m; size = msz;
        imm = IMM_W'(instr[4:0]) << msz;
      end
      5'b10010: begin
        illegal = 1'b0; cls = CLS_LOAD; is_load = 1'b1; wr_en = 1'b1; use_imm = 1'b1;
        src_a = REG_SP; dst = rx_m; size = SZ_WORD;
        imm = IMM_W'(instr[7:0]) << 2;
      end
      5'b11010: begin
        illegal = 1'b0; cls = CLS_STORE; is_store = 1'b1; use_imm = 1'b1;
        src_a = REG_SP; src_b = rx_m; size = SZ_WORD;
        imm = IMM_W'(instr[7:0]) << 2;
      end
      5'b01000: begin
        if (!instr[4]) begin
          illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1; use_imm = 1'b1;
          src_a = rx_m; dst = ry_m;
          imm = {{(IMM_W-4){instr[3]}}, instr[3:0]};
        end
      end
      5'b01001: begin
        illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1; use_imm = 1'b1;
        src_a = rx_m; dst = rx_m;
        imm = {{(IMM_W-8){instr[7]}}, instr[7:0]};
      end
      5'b01101: begin
        illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1; use_imm = 1'b1; alu_op = ALU_OR;
        dst = rx_m; imm = IMM_W'(instr[7:0]);
      end
      5'b01010, 5'b01011, 5'b01110: begin
        illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1; use_imm = 1'b1;
        alu_op = major[2] ? ALU_XOR : (major[0] ? ALU_SLTU : ALU_SLT);
        src_a = rx_m; dst = REG_CMP; imm = IMM_W'(instr[7:0]);
      end
      5'b00110: begin
        if (fn2 != 2'b01) begin
          illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1; use_imm = 1'b1;
          alu_op = (fn2 == 2'b00) ? ALU_SLL : ((fn2 == 2'b10) ? ALU_SRL : ALU_SRA);
          src_a = ry_m; dst = rx_m;
          imm = (shamt == 3'd0) ? IMM_W'(8) : IMM_W'(shamt);
        end
      end
      5'b11100: begin
        if (fn2[0]) begin
          illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1;
          alu_op = fn2[1] ? ALU_SUB : ALU_ADD;
          src_a = rx_m; src_b = ry_m; dst = rz_m;
        end
      end
      5'b11101: begin
        illegal = 1'b0; cls = CLS_ALU; wr_en = 1'b1;
        src_a = rx_m; src_b = ry_m; dst = rx_m;
        case (fn5)
          5'b00010: begin alu_op = ALU_SLT;  dst = REG_CMP; end
          5'b00011: begin alu_op = ALU_SLTU; dst = REG_CMP; end
          5'b01010: begin alu_op = ALU_XOR;  dst = REG_CMP; end
          5'b01011: begin alu_op = ALU_SUB;  src_a = REG_ZERO; end
          5'b01100: alu_op = ALU_AND;
          5'b01101: alu_op = ALU_OR;
          5'b01110: alu_op = ALU_XOR;
          5'b01111: begin alu_op = ALU_NOR;  src_a = REG_ZERO; end
          5'b11000, 5'b11001, 5'b11010, 5'b11011: begin
            cls = CLS_MULDIV; wr_en = 1'b0; dst = REG_ZERO;
            alu_op = alu_op_e'(4'(ALU_MULT) + 4'(fn5[1:0]));
          end
          default: begin
            illegal = 1'b1; cls = CLS_NONE; wr_en = 1'b0;
            src_a = REG_ZERO; src_b = REG_ZERO; dst = REG_ZERO;
          end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/m16_out_stage.sv
module m16_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/m16_decoder.sv
module m16_decoder
  import m16_dec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_instr,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [2:0]         out_class,
  output logic [3:0]         out_alu_op,
  output logic [4:0]         out_src_a,
  output logic [4:0]         out_src_b,
  output logic [4:0]         out_dst,
  output logic [IMM_W-1:0]   out_imm,
  output logic               out_use_imm,
  output logic [1:0]         out_size,
  output logic               out_unsigned,
  output logic               out_is_load,
  output logic               out_is_store,
  output logic               out_wr_en,
  output logic               out_illegal
);
  localparam int NFIELD   = 3;
  localparam int BUNDLE_W = 3 + 4 + 3 * REG_W + IMM_W + 1 + SIZE_W + 5;

  logic [FIELD_W-1:0] fld  [NFIELD];
  logic [REG_W-1:0]   mreg [NFIELD];

  assign fld[0] = in_instr[10:8];
  assign fld[1] = in_instr[7:5];
  assign fld[2] = in_instr[4:2];

  for (genvar g = 0; g < NFIELD; g++) begin : g_map
    m16_regmap u_map (.fld(fld[g]), .reg_idx(mreg[g]));
  end

  logic [2:0]        d_cls;
  logic [3:0]        d_op;
  logic [REG_W-1:0]  d_a, d_b, d_d;
  logic [IMM_W-1:0]  d_imm;
  logic [SIZE_W-1:0] d_sz;
  logic              d_ui, d_un, d_ld, d_st, d_wr, d_ill;

  m16_decode_core #(.IMM_W(IMM_W)) u_core (
    .instr(in_instr), .rx_m(mreg[0]), .ry_m(mreg[1]), .rz_m(mreg[2]),
    .cls(d_cls), .alu_op(d_op), .src_a(d_a), .src_b(d_b), .dst(d_d),
    .imm(d_imm), .use_imm(d_ui), .size(d_sz), .uns(d_un),
    .is_load(d_ld), .is_store(d_st), .wr_en(d_wr), .illegal(d_ill)
  );

  logic [BUNDLE_W-1:0] b_in, b_out;
  assign b_in = {d_cls, d_op, d_a, d_b, d_d, d_imm, d_ui, d_sz, d_un, d_ld, d_st, d_wr, d_ill};

  m16_out_stage #(.W(BUNDLE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(b_in),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(b_out)
  );

  assign {out_class, out_alu_op, out_src_a, out_src_b, out_dst, out_imm, out_use_imm,
          out_size, out_unsigned, out_is_load, out_is_store, out_wr_en, out_illegal} = b_out;
endmodule

// File: rtl/m16_decoder_chk.sv
module m16_decoder_chk #(
  parameter int IMM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [2:0]       out_class,
  input logic [3:0]       out_alu_op,
  input logic [4:0]       out_dst,
  input logic [IMM_W-1:0] out_imm,
  input logic             out_use_imm,
  input logic             out_is_load,
  input logic             out_is_store,
  input logic             out_wr_en,
  input logic             out_illegal
);
  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_dst)
      && $stable(out_alu_op) && $stable(out_class));

  p_dst_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> (out_dst >= 5'd2 && out_dst <= 5'd7) || out_dst == 5'd16
      || out_dst == 5'd17 || out_dst == 5'd24);

  p_one_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_is_load && out_is_store));

  p_cmp_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd0 && (out_alu_op == 4'd6 || out_alu_op == 4'd7) |-> out_dst == 5'd24);

  p_muldiv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd3 |-> !out_wr_en);

  p_illegal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wr_en && !out_is_load && !out_is_store && out_class == 3'd4);

  p_no_imm_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_use_imm |-> out_imm == '0);
endmodule

bind m16_decoder m16_decoder_chk #(.IMM_W(IMM_W)) u_chk (.*);

// File: tb/m16_decoder_tb.sv
module m16_decoder_tb;
  localparam int IMM_W = 32;
  localparam int BW = 30 + IMM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_instr = '0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [2:0] out_class;
  logic [3:0] out_alu_op;
  logic [4:0] out_src_a, out_src_b, out_dst;
  logic [IMM_W-1:0] out_imm;
  logic out_use_imm, out_unsigned, out_is_load, out_is_store, out_wr_en, out_illegal;
  logic [1:0] out_size;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  m16_decoder #(.IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .out_ready(out_ready), .out_valid(out_valid), .out_class(out_class), .out_alu_op(out_alu_op),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst), .out_imm(out_imm),
    .out_use_imm(out_use_imm), .out_size(out_size), .out_unsigned(out_unsigned),
    .out_is_load(out_is_load), .out_is_store(out_is_store), .out_wr_en(out_wr_en),
    .out_illegal(out_illegal)
  );

  function automatic logic [4:0] rmap(input logic [2:0] f);
    case (f)
      3'd0: return 5'd16;
      3'd1: return 5'd17;
      default: return {2'b00, f};
    endcase
  endfunction

  // field layout: cls,op,a,b,d,imm,ui,sz,un,ld,st,wr,ill
  function automatic logic [BW-1:0] pack(input int c, input int op, input logic [4:0] a,
      input logic [4:0] b, input logic [4:0] d, input logic [IMM_W-1:0] im, input bit ui,
      input int sz, input bit un, input bit ld, input bit st, input bit wr);
    return {3'(c), 4'(op), a, b, d, im, ui, 2'(sz), un, ld, st, wr, 1'b0};
  endfunction

  function automatic logic [BW-1:0] model(input logic [15:0] w);
    logic [4:0] x, y, z;
    logic [IMM_W-1:0] u5, u8, s8, s4;
    x = rmap(w[10:8]); y = rmap(w[7:5]); z = rmap(w[4:2]);
    u5 = IMM_W'(w[4:0]); u8 = IMM_W'(w[7:0]);
    s8 = IMM_W'($signed(w[7:0])); s4 = IMM_W'($signed(w[3:0]));
    case (w[15:11])
      5'b10000: return pack(1, 0, x, 0, y, u5,     1, 0, 0, 1, 0, 1);
      5'b10100: return pack(1, 0, x, 0, y, u5,     1, 0, 1, 1, 0, 1);
      5'b10001: return pack(1, 0, x, 0, y, u5 * 2, 1, 1, 0, 1, 0, 1);
      5'b10101: return pack(1, 0, x, 0, y, u5 * 2, 1, 1, 1, 1, 0, 1);
      5'b10011: return pack(1, 0, x, 0, y, u5 * 4, 1, 2, 0, 1, 0, 1);
      5'b11000: return pack(2, 0, x, y, 0, u5,     1, 0, 0, 0, 1, 0);
      5'b11001: return pack(2, 0, x, y, 0, u5 * 2, 1, 1, 0, 0, 1, 0);
      5'b11011: return pack(2, 0, x, y, 0, u5 * 4, 1, 2, 0, 0, 1, 0);
      5'b10010: return pack(1, 0, 29, 0, x, u8 * 4, 1, 2, 0, 1, 0, 1);
      5'b11010: return pack(2, 0, 29, x, 0, u8 * 4, 1, 2, 0, 0, 1, 0);
      5'b01000: if (w[4] == 1'b0) return pack(0, 0, x, 0, y, s4, 1, 0, 0, 0, 0, 1);
      5'b01001: return pack(0, 0, x, 0, x, s8, 1, 0, 0, 0, 0, 1);
      5'b01101: return pack(0, 3, 0, 0, x, u8, 1, 0, 0, 0, 0, 1);
      5'b01010: return pack(0, 6, x, 0, 24, u8, 1, 0, 0, 0, 0, 1);
      5'b01011: return pack(0, 7, x, 0, 24, u8, 1, 0, 0, 0, 0, 1);
      5'b01110: return pack(0, 4, x, 0, 24, u8, 1, 0, 0, 0, 0, 1);
      5'b00110: begin
        int amt = (w[4:2] == 0) ? 8 : int'(w[4:2]);
        case (w[1:0])
          2'b00: return pack(0, 8,  y, 0, x, IMM_W'(amt), 1, 0, 0, 0, 0, 1);
          2'b10: return pack(0, 9,  y, 0, x, IMM_W'(amt), 1, 0, 0, 0, 0, 1);
          2'b11: return pack(0, 10, y, 0, x, IMM_W'(amt), 1, 0, 0, 0, 0, 1);
          default: ;
        endcase
      end
      5'b11100: begin
        if (w[1:0] == 2'b01) return pack(0, 0, x, y, z, 0, 0, 0, 0, 0, 0, 1);
        if (w[1:0] == 2'b11) return pack(0, 1, x, y, z, 0, 0, 0, 0, 0, 0, 1);
      end
      5'b11101: begin
        case (w[4:0])
          5'b00010: return pack(0, 6, x, y, 24, 0, 0, 0, 0, 0, 0, 1);
          5'b00011: return pack(0, 7, x, y, 24, 0, 0, 0, 0, 0, 0, 1);
          5'b01010: return pack(0, 4, x, y, 24, 0, 0, 0, 0, 0, 0, 1);
          5'b01011: return pack(0, 1, 0, y, x, 0, 0, 0, 0, 0, 0, 1);
          5'b01100: return pack(0, 2, x, y, x, 0, 0, 0, 0, 0, 0, 1);
          5'b01101: return pack(0, 3, x, y, x, 0, 0, 0, 0, 0, 0, 1);
          5'b01110: return pack(0, 4, x, y, x, 0, 0, 0, 0, 0, 0, 1);
          5'b01111: return pack(0, 5, 0, y, x, 0, 0, 0, 0, 0, 0, 1);
          5'b11000: return pack(3, 11, x, y, 0, 0, 0, 0, 0, 0, 0, 0);
          5'b11001: return pack(3, 12, x, y, 0, 0, 0, 0, 0, 0, 0, 0);
          5'b11010: return pack(3, 13, x, y, 0, 0, 0, 0, 0, 0, 0, 0);
          5'b11011: return pack(3, 14, x, y, 0, 0, 0, 0, 0, 0, 0, 0);
          default: ;
        endcase
      end
      default: ;
    endcase
    return {3'd4, {(BW-4){1'b0}}, 1'b1};  // R12 illegal bundle
  endfunction

  function automatic string req_of(input logic [15:0] w);
    case (w[15:11])
      5'b10000, 5'b10100, 5'b10001, 5'b10101, 5'b10011,
      5'b11000, 5'b11001, 5'b11011: return "R4 (R2 R3)";
      5'b10010, 5'b11010:           return "R5";
      5'b01000, 5'b01001, 5'b01101: return "R6 (R12 R13)";
      5'b01010, 5'b01011, 5'b01110: return "R7";
      5'b00110:                     return "R8 (R12)";
      5'b11100:                     return "R9 (R12)";
      5'b11101:                     return "R10 R11 (R12 R13)";
      default:                      return "R12";
    endcase
  endfunction

  function automatic logic [BW-1:0] got();
    return {out_class, out_alu_op, out_src_a, out_src_b, out_dst, out_imm, out_use_imm,
            out_size, out_unsigned, out_is_load, out_is_store, out_wr_en, out_illegal};
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_word(input logic [15:0] w);
    logic [BW-1:0] e;
    e = model(w);
    check(out_valid === 1'b1 && got() === e, req_of(w), {out_valid, got()}, {1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 reset", BW'({out_valid, in_ready}), BW'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    // R2..R13 full sweep, one word per cycle with the consumer ready
    for (int i = 0; i < 65536; i++) begin
      in_valid = 1'b1;
      in_instr = 16'(i);
      @(negedge clk);
      check_word(16'(i));
    end
    // R1 stall: last word (0xFFFF) must be held, new word refused
    out_ready = 1'b0;
    in_instr  = 16'h9C42;
    @(negedge clk);
    check(in_ready === 1'b0, "R1 stall ready", BW'(in_ready), BW'(0));
    check_word(16'hFFFF);
    @(negedge clk);
    check_word(16'hFFFF);
    // R1 release: the waiting word is taken
    out_ready = 1'b1;
    @(negedge clk);
    check_word(16'h9C42);
    // R1 idle clears out_valid
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle", BW'({out_valid, in_ready}), BW'(2'b01));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule